// File: doc/BRIEF.md
# Truncating Serial Audio Input Latch

This block is the receive front end of a downstream audio filter. It runs on the serial bit clock. On every rising edge it shifts one data bit, MSB first, into a 16-bit register. When the channel-select (left/right) line changes level, it copies the register into a parallel sample word. It tags that word with the channel level that was in force while the bits arrived. It then raises a valid strobe for exactly one bit-clock period.

The sender may carry more bits per channel than the register holds. A typical case is a 24-bit word inside a 32-clock half-frame, with the channel line delayed so that the word's MSB arrives 16 clocks before the channel edge. In that case the latch keeps only the 16 most significant bits.

No explicit truncation logic exists. The trailing low bits arrive after the latch point. Everything sent earlier in the half-frame has already been pushed out of the register's far end before the latch.

Top module: `trunc_audio_latch`

## Requirements
- R1: While the active-low reset is low, the sample output is 0, the channel output is 0 and the valid output is 0, without waiting for a clock edge.
- R2: The serial data input is sampled on every rising bit-clock edge, and earlier bits move toward the sample MSB.
- R3: When the channel line is seen at a new level on a rising edge, the sample output after that edge holds the 16 bits sampled on the 16 preceding edges. The earliest of those bits is in bit 15 and the latest in bit 0.
- R4: Consider a 24-bit word whose MSB arrives 16 edges before the channel change, with its 8 low bits sent just after the change. For such a word the sample output equals word bits 23..8. The word's low bits, any padding, and the previous channel's bits earlier in the half-frame have no effect on it.
- R5: With each new sample, the channel output equals the channel line level sampled just before the change, that is, the level during which the sample's bits arrived.
- R6: The valid output is high for the single bit-clock period after an edge on which a channel change is seen, and low in every other period.
- R7: After reset is released, the first channel level sampled is only taken as a reference. No valid strobe is produced until the line later changes level, whatever level it held at release.
- R8: Between changes, the sample and channel outputs keep their last latched values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sdata_i | input | 1 | Serial audio data, MSB first |
| lrck_i | input | 1 | Channel-select line; each level change closes a channel word |
| sample_o | output | 16 | Latched sample word |
| chan_o | output | 1 | Channel level of the latched sample |
| valid_o | output | 1 | One-period strobe marking a new sample |

## Verification
A channel change driven before rising edge n shows up on all three outputs directly after edge n, one register stage from the pins. The bench drives inputs on falling edges and compares the outputs on the next falling edge against an expectation it computed when it drove the previous slot. Every output is therefore checked half a period after the edge that updates it.

The sample expected at each change is the upper 16 bits of the word the bench placed in the closing half-frame. Its position in the stream follows from the 32-slot layout alone. Reset is checked one nanosecond after it is asserted, between clock edges.

// File: rtl/trunc_latch_pkg.sv
`timescale 1ns/1ps
package trunc_latch_pkg;
  localparam int unsigned DEF_SAMPLE_W = 16;

  typedef enum logic {
    LR_LOW  = 1'b0,
    LR_HIGH = 1'b1
  } lr_lvl_e;
endpackage

// File: rtl/tal_shift.sv
`timescale 1ns/1ps
module tal_shift #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sr_q;

  generate
    if (W == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= bit_i;
    end else begin : g_multi
      // oldest bit falls off the MSB end: this is the truncation
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[W-2:0], bit_i};
    end
  endgenerate

  assign word_o = sr_q;
endmodule

// File: rtl/tal_lr_edge.sv
`timescale 1ns/1ps
module tal_lr_edge
  import trunc_latch_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    lrck_i,
  output logic    fire_o,
  output lr_lvl_e prev_o
);
  logic lvl_q;
  logic primed_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      lvl_q    <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      lvl_q    <= lrck_i;
      primed_q <= 1'b1;
    end

  // first sample after reset is reference only
  assign fire_o = primed_q && (lrck_i != lvl_q);
  assign prev_o = lr_lvl_e'(lvl_q);
endmodule

// File: rtl/tal_out_reg.sv
`timescale 1ns/1ps
module tal_out_reg
  import trunc_latch_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fire_i,
  input  logic [W-1:0] word_i,
  input  lr_lvl_e      chan_i,
  output logic [W-1:0] sample_o,
  output logic         chan_o,
  output logic         valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sample_o <= '0;
      chan_o   <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) begin
        sample_o <= word_i;
        chan_o   <= logic'(chan_i);
      end
    end
endmodule

// File: rtl/trunc_audio_latch.sv
`timescale 1ns/1ps
module trunc_audio_latch
  import trunc_latch_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sdata_i,
  input  logic                lrck_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                chan_o,
  output logic                valid_o
);
  logic [SAMPLE_W-1:0] shift_word;
  logic                fire;
  lr_lvl_e             prev_lvl;

  tal_shift #(.W(SAMPLE_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (sdata_i),
    .word_o (shift_word)
  );

  tal_lr_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lrck_i (lrck_i),
    .fire_o (fire),
    .prev_o (prev_lvl)
  );

  tal_out_reg #(.W(SAMPLE_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .word_i   (shift_word),
    .chan_i   (prev_lvl),
    .sample_o (sample_o),
    .chan_o   (chan_o),
    .valid_o  (valid_o)
  );

  assert_sample_lsb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sample_o[0] == $past(sdata_i, 2));

  assert_chan_prev_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> chan_o == $past(lrck_i, 2));

  assert_valid_on_change_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(lrck_i) != $past(lrck_i, 2));

  assert_hold_between_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(sample_o) && $stable(chan_o)));
endmodule

// File: tb/trunc_audio_latch_tb_top.sv
`timescale 1ns/1ps
module trunc_audio_latch_tb_top;
  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic         sdata_i = 1'b0;
  logic         lrck_i = 1'b0;
  logic [W-1:0] sample_o;
  logic         chan_o;
  logic         valid_o;

  always #2.5 clk_i = ~clk_i;

  trunc_audio_latch #(.SAMPLE_W(W)) dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sdata_i  (sdata_i),
    .lrck_i   (lrck_i),
    .sample_o (sample_o),
    .chan_o   (chan_o),
    .valid_o  (valid_o)
  );

  int           errors = 0;
  int           checks = 0;
  bit           done = 0;
  logic         exp_valid = 1'b0;
  logic         exp_chan = 1'b0;
  logic [W-1:0] exp_sample = '0;
  logic [W-1:0] pend = '0;
  logic [7:0]   tail = '0;
  logic         prev_lv = 1'b0;
  logic         have_prev = 1'b0;
  logic [23:0]  lfsr = 24'h5A3C17;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_bit(input logic b, input logic lv);
    @(negedge clk_i);
    chk("R6 valid strobe", valid_o, exp_valid);
    if (exp_valid) begin
      chk("R3/R4 sample", sample_o, exp_sample);
      chk("R5 channel", chan_o, exp_chan);
    end else begin
      chk("R8 sample hold", sample_o, exp_sample);
    end
    if (have_prev && lv != prev_lv) begin
      exp_valid  = 1'b1;
      exp_sample = pend;
      exp_chan   = prev_lv;
    end else begin
      exp_valid = 1'b0;
    end
    prev_lv   = lv;
    have_prev = 1'b1;
    sdata_i   = b;
    lrck_i    = lv;
  endtask

  // 32 slots: previous word's 8 LSBs, 8 pad, this word's 16 MSBs (R2, R4)
  task automatic send_half(input logic lv, input logic [23:0] w, input logic [7:0] pad);
    for (int i = 0; i < 8; i++)  drive_bit(tail[7-i], lv);
    for (int i = 0; i < 8; i++)  drive_bit(pad[7-i], lv);
    for (int i = 0; i < 16; i++) drive_bit(w[23-i], lv);
    tail = w[7:0];
    pend = w[23:8];
  endtask

  task automatic do_reset(input logic start_lv);
    @(posedge clk_i);
    #1;
    rst_ni  = 1'b0;
    sdata_i = 1'b1;
    lrck_i  = start_lv;
    #1;
    chk("R1 reset sample", sample_o, '0);
    chk("R1 reset chan", chan_o, 1'b0);
    chk("R1 reset valid", valid_o, 1'b0);
    exp_valid  = 1'b0;
    exp_chan   = 1'b0;
    exp_sample = '0;
    pend       = '0;
    tail       = '0;
    have_prev  = 1'b0;
    prev_lv    = start_lv;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  function automatic logic [23:0] next_lfsr(input logic [23:0] s);
    logic [23:0] x;
    x = s ^ (s << 7);
    x = x ^ (x >> 9);
    x = x ^ (x << 8);
    return (x == 24'h0) ? 24'h1 : x;
  endfunction

  initial begin
    logic lv;
    // R7: line high at release, first half-frame high too
    do_reset(1'b1);
    lv = 1'b1;
    for (int i = 0; i < 24; i++) begin
      send_half(lv, 24'h1 << i, 8'h00);
      lv = ~lv;
    end
    // R4: noisy padding and tails must not leak into the sample
    for (int i = 0; i < 40; i++) begin
      lfsr = next_lfsr(lfsr);
      send_half(lv, lfsr, lfsr[15:8] ^ 8'hC3);
      lv = ~lv;
    end
    // R1/R7: mid-stream reset, restart low
    do_reset(1'b0);
    lv = 1'b0;
    send_half(lv, 24'hFFFFFF, 8'hFF); lv = ~lv;
    send_half(lv, 24'h000000, 8'hFF); lv = ~lv;
    send_half(lv, 24'h800000, 8'h00); lv = ~lv;
    send_half(lv, 24'h0000FF, 8'hFF); lv = ~lv;
    send_half(lv, 24'h0001FF, 8'h00); lv = ~lv;
    send_half(lv, 24'hA5C33C, 8'h5A); lv = ~lv;
    // close last word and observe strobe fall (R6, R8)
    for (int i = 0; i < 4; i++) drive_bit(1'b0, lv);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R6 watchdog act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule